// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the sequencing core of one DMA channel. Software programs a source base address, a destination base address and a byte count through a small register port, then sets a trigger bit. The engine runs beats. Each beat reads one item from the current source address and then writes that item to the current destination address over a generic bus master port. After each completed beat it updates the running source address, the running destination address and the remaining byte count.

Three transfer modes are supported. In memory-to-memory mode, word beats run back to back. In the two peripheral modes, each beat waits for the peripheral request input, and the beat width is programmable as byte, half-word or word. Each address pointer is set on its own to increment, stay fixed or wrap. Wrap means the pointer increments, and when the count runs out the running addresses and count reload from the programmed values and the channel restarts without a new trigger. The channel also provides an enable, a soft engine reset that keeps the configuration, and a halt on a bus error response.

Register index map (`reg_idx_i`):

| Index | Contents |
|---|---|
| 0 | control |
| 1 | source base |
| 2 | destination base |
| 3 | count base |
| 4 | current source (read-only) |
| 5 | current destination (read-only) |
| 6 | current count (read-only) |
| 7 | status, bit 0 = error latched (read-only) |

Control bit positions:

| Bits | Field |
|---|---|
| 0 | enable |
| 1 | soft reset |
| 2 | trigger |
| 5:4 | mode |
| 7:6 | source direction |
| 9:8 | destination direction |
| 11:10 | beat width |

Top module: `dma_seq_top`

## Requirements
- R1: After reset, `bus_req_o`, `done_o` and `err_o` are 0 and every register index reads 0.
- R2: A beat reads at the current source address (`bus_we_o`=0) and then writes the data it read to the current destination address (`bus_we_o`=1). In mode 00 (memory-to-memory) beats follow each other without any peripheral request.
- R3: In mode 01 (peripheral-to-memory) and mode 10 (memory-to-peripheral), a beat's read starts only after a cycle in which `periph_req_i` was high. While `periph_req_i` stays low, no bus request is made.
- R4: Beat size is 4 bytes in mode 00. In peripheral modes it follows the width field: 00 gives 4 bytes, 01 gives 1 byte, 10 gives 2 bytes, and 11 gives 4 bytes. `bus_size_o` is 0, 1 or 2 for 1, 2 or 4 bytes. Each beat lowers the current count by the beat size.
- R5: A direction value of 00 (increment) or 11 (wrap) advances its address by the beat size on each completed beat. A value of 10 (fixed) or 01 (reserved) holds the address.
- R6: Setting the trigger loads the current addresses and count from the bases. The trigger bit reads back as 1 while the run is active. When the count reaches 0 the trigger bit clears itself and `done_o` pulses high for exactly one cycle.
- R7: If either direction is 11 when the count reaches 0 and the channel is enabled, the addresses and count reload from the bases and beats continue. `done_o` does not pulse and the trigger bit stays set.
- R8: While enable (bit 0) is 0, no read is issued and peripheral requests are ignored. A pending trigger stays set, and the run resumes from the current pointers once enable returns to 1.
- R9: An error response to a request stops the channel. `err_o` goes high, the trigger bit clears, and the pointers do not advance. Until a soft reset, `bus_req_o` stays 0 and a new trigger is ignored.
- R10: Writing control with bit 1 set clears the engine state, the current addresses, the count, the trigger and `err_o`. The configuration fields and base registers are unchanged, and bit 1 reads back as 0.
- R11: A trigger written with mode 11 is ignored: the trigger bit stays 0 and no bus request is made.
- R12: A trigger with a count base of 0 completes at once, with a single `done_o` pulse and no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| reg_we_i | input | 1 | register write strobe |
| reg_idx_i | input | 3 | register index for write and read |
| reg_wdata_i | input | 32 | register write data |
| reg_rdata_o | output | 32 | register read data for `reg_idx_i` |
| bus_req_o | output | 1 | bus request, held until ack or error |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 32 | bus address |
| bus_size_o | output | 2 | beat size code (0 byte, 1 half-word, 2 word) |
| bus_wdata_o | output | 32 | write data |
| bus_rdata_i | input | 32 | read data, valid with ack |
| bus_ack_i | input | 1 | transfer completed |
| bus_err_i | input | 1 | error response |
| periph_req_i | input | 1 | peripheral service request |
| done_o | output | 1 | one-cycle run-complete pulse |
| err_o | output | 1 | bus error latched |

## Verification
The assertions assume the following about the inputs:
- `bus_ack_i` and `bus_err_i` are only meaningful while a request is up and are never high together.
- The mode field is not rewritten while a run is active, so the peripheral gating property can read the mode live.

The bench's bus responder keeps to these assumptions. It answers each request with exactly one single-cycle ack or error and drops it the cycle after. The bench also changes only the enable bit during a run, and it programs only word-aligned bases with counts that are multiples of the beat size.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int REG_IDX_W = 3;
  localparam int BEAT_W    = 3;

  localparam logic [REG_IDX_W-1:0] RIDX_CTRL  = 3'd0;
  localparam logic [REG_IDX_W-1:0] RIDX_SBASE = 3'd1;
  localparam logic [REG_IDX_W-1:0] RIDX_DBASE = 3'd2;
  localparam logic [REG_IDX_W-1:0] RIDX_CBASE = 3'd3;
  localparam logic [REG_IDX_W-1:0] RIDX_SCUR  = 3'd4;
  localparam logic [REG_IDX_W-1:0] RIDX_DCUR  = 3'd5;
  localparam logic [REG_IDX_W-1:0] RIDX_CCUR  = 3'd6;
  localparam logic [REG_IDX_W-1:0] RIDX_STAT  = 3'd7;

  localparam int CB_EN   = 0;
  localparam int CB_SRST = 1;
  localparam int CB_TRIG = 2;
  localparam int CB_MODE = 4;
  localparam int CB_SDIR = 6;
  localparam int CB_DDIR = 8;
  localparam int CB_WID  = 10;

  typedef enum logic [1:0] {
    MODE_M2M = 2'b00,
    MODE_P2M = 2'b01,
    MODE_M2P = 2'b10,
    MODE_RSV = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    DIR_INC  = 2'b00,
    DIR_RSV  = 2'b01,
    DIR_FIX  = 2'b10,
    DIR_WRAP = 2'b11
  } addr_dir_e;

  typedef enum logic [1:0] {
    WID_W32 = 2'b00,
    WID_B8  = 2'b01,
    WID_H16 = 2'b10,
    WID_RSV = 2'b11
  } beat_wid_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RD   = 2'b01,
    ST_WR   = 2'b10
  } seq_state_e;

  typedef struct packed {
    logic       en;
    xfer_mode_e mode;
    addr_dir_e  sdir;
    addr_dir_e  ddir;
    beat_wid_e  wid;
  } chan_cfg_t;

  function automatic logic [BEAT_W-1:0] beat_bytes(xfer_mode_e m, beat_wid_e w);
    if (m == MODE_M2M) return BEAT_W'(4);
    case (w)
      WID_B8:  return BEAT_W'(1);
      WID_H16: return BEAT_W'(2);
      default: return BEAT_W'(4);
    endcase
  endfunction

  function automatic logic [1:0] size_code(logic [BEAT_W-1:0] b);
    case (b)
      BEAT_W'(1): return 2'd0;
      BEAT_W'(2): return 2'd1;
      default:    return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [REG_IDX_W-1:0] idx_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output chan_cfg_t            cfg_o,
  output logic [ADDR_W-1:0]    sbase_o,
  output logic [ADDR_W-1:0]    dbase_o,
  output logic [CNT_W-1:0]     cbase_o,
  output logic                 srst_o,
  output logic                 trig_req_o
);

  logic ctrl_hit;
  chan_cfg_t cfg_q;

  assign ctrl_hit = we_i && (idx_i == RIDX_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      sbase_o <= '0;
      dbase_o <= '0;
      cbase_o <= '0;
    end else if (we_i) begin
      case (idx_i)
        RIDX_CTRL: begin
          // soft reset write leaves the configuration alone
          if (!wdata_i[CB_SRST]) begin
            cfg_q.en   <= wdata_i[CB_EN];
            cfg_q.mode <= xfer_mode_e'(wdata_i[CB_MODE +: 2]);
            cfg_q.sdir <= addr_dir_e'(wdata_i[CB_SDIR +: 2]);
            cfg_q.ddir <= addr_dir_e'(wdata_i[CB_DDIR +: 2]);
            cfg_q.wid  <= beat_wid_e'(wdata_i[CB_WID +: 2]);
          end
        end
        RIDX_SBASE: sbase_o <= wdata_i[ADDR_W-1:0];
        RIDX_DBASE: dbase_o <= wdata_i[ADDR_W-1:0];
        RIDX_CBASE: cbase_o <= wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  assign cfg_o      = cfg_q;
  assign srst_o     = ctrl_hit && wdata_i[CB_SRST];
  assign trig_req_o = ctrl_hit && wdata_i[CB_TRIG] && !wdata_i[CB_SRST]
                      && (wdata_i[CB_MODE +: 2] != MODE_RSV);

endmodule

// File: rtl/dma_seq_ptr.sv
module dma_seq_ptr
  import dma_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic              step_i,
  input  addr_dir_e         dir_i,
  input  logic [AW-1:0]     base_i,
  input  logic [BEAT_W-1:0] inc_i,
  output logic [AW-1:0]     cur_o
);

  logic advance;
  assign advance = (dir_i == DIR_INC) || (dir_i == DIR_WRAP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cur_o <= '0;
    else if (clr_i)             cur_o <= '0;
    else if (load_i)            cur_o <= base_i;
    else if (step_i && advance) cur_o <= cur_o + AW'(inc_i);
  end

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  chan_cfg_t         cfg_i,
  input  logic [CNT_W-1:0]  cbase_i,
  input  logic              srst_i,
  input  logic              trig_req_i,
  input  logic              periph_req_i,
  input  logic              bus_ack_i,
  input  logic              bus_err_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output seq_state_e        state_o,
  output logic              trig_o,
  output logic              err_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  ccur_o,
  output logic [DATA_W-1:0] buf_o,
  output logic              load_o,
  output logic              step_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              bus_req_o
);

  seq_state_e        state_q, state_d;
  logic              trig_q, trig_d, err_q, err_d, done_q, done_d;
  logic [CNT_W-1:0]  ccur_q, ccur_d, cnt_step, cnt_nxt;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              periph_ok, wrap_any, trig_take, load, step;

  assign beat_o    = beat_bytes(cfg_i.mode, cfg_i.wid);
  assign cnt_step  = CNT_W'(beat_o);
  assign cnt_nxt   = (ccur_q <= cnt_step) ? '0 : ccur_q - cnt_step;
  assign periph_ok = (cfg_i.mode == MODE_M2M) || periph_req_i;
  assign wrap_any  = (cfg_i.sdir == DIR_WRAP) || (cfg_i.ddir == DIR_WRAP);
  assign trig_take = trig_req_i && !err_q && !trig_q;

  always_comb begin
    state_d = state_q;
    trig_d  = trig_q;
    err_d   = err_q;
    done_d  = 1'b0;
    ccur_d  = ccur_q;
    buf_d   = buf_q;
    load    = 1'b0;
    step    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (trig_q && cfg_i.en && !err_q) begin
          if (ccur_q == '0) begin
            trig_d = 1'b0;
            done_d = 1'b1;
          end else if (periph_ok) begin
            state_d = ST_RD;
          end
        end
      end
      ST_RD: begin
        if (!cfg_i.en) begin
          state_d = ST_IDLE;          // read abandoned, nothing buffered
        end else if (bus_err_i) begin
          err_d   = 1'b1;
          trig_d  = 1'b0;
          state_d = ST_IDLE;
        end else if (bus_ack_i) begin
          buf_d   = bus_rdata_i;
          state_d = ST_WR;
        end
      end
      ST_WR: begin
        if (bus_err_i) begin
          err_d   = 1'b1;
          trig_d  = 1'b0;
          state_d = ST_IDLE;
        end else if (bus_ack_i) begin
          state_d = ST_IDLE;
          step    = 1'b1;
          ccur_d  = cnt_nxt;
          if (cnt_nxt == '0) begin
            if (wrap_any && cfg_i.en) begin
              load   = 1'b1;
              ccur_d = cbase_i;
            end else begin
              trig_d = 1'b0;
              done_d = 1'b1;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (trig_take) begin
      trig_d = 1'b1;
      load   = 1'b1;
      ccur_d = cbase_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      trig_q  <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      ccur_q  <= '0;
      buf_q   <= '0;
    end else if (srst_i) begin
      state_q <= ST_IDLE;
      trig_q  <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      ccur_q  <= '0;
      buf_q   <= '0;
    end else begin
      state_q <= state_d;
      trig_q  <= trig_d;
      err_q   <= err_d;
      done_q  <= done_d;
      ccur_q  <= ccur_d;
      buf_q   <= buf_d;
    end
  end

  assign state_o   = state_q;
  assign trig_o    = trig_q;
  assign err_o     = err_q;
  assign done_o    = done_q;
  assign ccur_o    = ccur_q;
  assign buf_o     = buf_q;
  assign load_o    = load && !srst_i;
  assign step_o    = step && !srst_i;
  assign bus_req_o = ((state_q == ST_RD) && cfg_i.en) || (state_q == ST_WR);

endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [REG_IDX_W-1:0] reg_idx_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic                 bus_req_o,
  output logic                 bus_we_o,
  output logic [ADDR_W-1:0]    bus_addr_o,
  output logic [1:0]           bus_size_o,
  output logic [DATA_W-1:0]    bus_wdata_o,
  input  logic [DATA_W-1:0]    bus_rdata_i,
  input  logic                 bus_ack_i,
  input  logic                 bus_err_i,
  input  logic                 periph_req_i,
  output logic                 done_o,
  output logic                 err_o
);

  localparam int NPTR = 2;  // 0 = source, 1 = destination

  chan_cfg_t         chan_cfg;
  logic [ADDR_W-1:0] sbase, dbase;
  logic [CNT_W-1:0]  cbase, cnt_cur;
  logic              soft_rst, trig_req, trig_act, ptr_load, ptr_step;
  seq_state_e        seq_state;
  logic [BEAT_W-1:0] beat_b;
  logic [ADDR_W-1:0] base_a [NPTR];
  logic [ADDR_W-1:0] cur_a  [NPTR];
  addr_dir_e         dir_a  [NPTR];

  dma_seq_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .idx_i      (reg_idx_i),
    .wdata_i    (reg_wdata_i),
    .cfg_o      (chan_cfg),
    .sbase_o    (sbase),
    .dbase_o    (dbase),
    .cbase_o    (cbase),
    .srst_o     (soft_rst),
    .trig_req_o (trig_req)
  );

  dma_seq_fsm #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_i        (chan_cfg),
    .cbase_i      (cbase),
    .srst_i       (soft_rst),
    .trig_req_i   (trig_req),
    .periph_req_i (periph_req_i),
    .bus_ack_i    (bus_ack_i),
    .bus_err_i    (bus_err_i),
    .bus_rdata_i  (bus_rdata_i),
    .state_o      (seq_state),
    .trig_o       (trig_act),
    .err_o        (err_o),
    .done_o       (done_o),
    .ccur_o       (cnt_cur),
    .buf_o        (bus_wdata_o),
    .load_o       (ptr_load),
    .step_o       (ptr_step),
    .beat_o       (beat_b),
    .bus_req_o    (bus_req_o)
  );

  assign base_a[0] = sbase;
  assign base_a[1] = dbase;
  assign dir_a[0]  = chan_cfg.sdir;
  assign dir_a[1]  = chan_cfg.ddir;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dma_seq_ptr #(.AW(ADDR_W)) u_ptr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (soft_rst),
      .load_i (ptr_load),
      .step_i (ptr_step),
      .dir_i  (dir_a[g]),
      .base_i (base_a[g]),
      .inc_i  (beat_b),
      .cur_o  (cur_a[g])
    );
  end

  assign bus_we_o   = (seq_state == ST_WR);
  assign bus_addr_o = bus_we_o ? cur_a[1] : cur_a[0];
  assign bus_size_o = size_code(beat_b);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_idx_i)
      RIDX_CTRL: begin
        reg_rdata_o[CB_EN]        = chan_cfg.en;
        reg_rdata_o[CB_TRIG]      = trig_act;
        reg_rdata_o[CB_MODE +: 2] = chan_cfg.mode;
        reg_rdata_o[CB_SDIR +: 2] = chan_cfg.sdir;
        reg_rdata_o[CB_DDIR +: 2] = chan_cfg.ddir;
        reg_rdata_o[CB_WID +: 2]  = chan_cfg.wid;
      end
      RIDX_SBASE: reg_rdata_o = DATA_W'(sbase);
      RIDX_DBASE: reg_rdata_o = DATA_W'(dbase);
      RIDX_CBASE: reg_rdata_o = DATA_W'(cbase);
      RIDX_SCUR:  reg_rdata_o = DATA_W'(cur_a[0]);
      RIDX_DCUR:  reg_rdata_o = DATA_W'(cur_a[1]);
      RIDX_CCUR:  reg_rdata_o = DATA_W'(cnt_cur);
      RIDX_STAT:  reg_rdata_o[0] = err_o;
      default: ;
    endcase
  end

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input chan_cfg_t        cfg_i,
  input logic             srst_i,
  input logic [CNT_W-1:0] ccur_i,
  input logic             bus_req_o,
  input logic             bus_we_o,
  input logic [1:0]       bus_size_o,
  input logic             bus_ack_i,
  input logic             bus_err_i,
  input logic             periph_req_i,
  input logic             done_o,
  input logic             err_o
);

  a_r2_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_we_o && bus_ack_i && !bus_err_i && cfg_i.en && !srst_i
    |=> bus_req_o && bus_we_o);

  a_r3_periph_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) && !bus_we_o && (cfg_i.mode != MODE_M2M) |-> $past(periph_req_i));

  a_r4_m2m_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && (cfg_i.mode == MODE_M2M) |-> bus_size_o == 2'd2);

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_no_read_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_we_o |-> cfg_i.en);

  a_r9_err_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_err_i && !srst_i |=> err_o && !bus_req_o);

  a_r9_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !bus_req_o);

  a_r10_srst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (ccur_i == '0) && !bus_req_o && !err_o);

endmodule

bind dma_seq_top dma_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_i        (chan_cfg),
  .srst_i       (soft_rst),
  .ccur_i       (cnt_cur),
  .bus_req_o    (bus_req_o),
  .bus_we_o     (bus_we_o),
  .bus_size_o   (bus_size_o),
  .bus_ack_i    (bus_ack_i),
  .bus_err_i    (bus_err_i),
  .periph_req_i (periph_req_i),
  .done_o       (done_o),
  .err_o        (err_o)
);

// File: tb/dma_seq_top_test.sv
module dma_seq_top_test;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_idx_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        bus_req_o, bus_we_o;
  logic [31:0] bus_addr_o, bus_wdata_o;
  logic [1:0]  bus_size_o;
  logic [31:0] bus_rdata_i = '0;
  logic        bus_ack_i = 1'b0, bus_err_i = 1'b0;
  logic        periph_req_i = 1'b0;
  logic        done_o, err_o;

  int n_chk = 0, n_fail = 0, txn_cnt = 0, done_cnt = 0;
  logic        inj_en = 1'b0, inj_we = 1'b0;
  logic [31:0] inj_addr = '0;

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
    logic [1:0]  size;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  dma_seq_top uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_idx_i(reg_idx_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .bus_req_o(bus_req_o),
    .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o), .bus_size_o(bus_size_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_ack_i(bus_ack_i),
    .bus_err_i(bus_err_i), .periph_req_i(periph_req_i), .done_o(done_o), .err_o(err_o)
  );

  function automatic logic [31:0] rdfn(logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] ctl(logic en, logic trig, logic [1:0] mode,
                                      logic [1:0] sd, logic [1:0] dd, logic [1:0] wid);
    return {20'h0, wid, dd, sd, mode, 1'b0, trig, 1'b0, en};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  // responder + monitor
  always @(negedge clk) begin
    if (done_o) done_cnt++;
    if (!rst_ni) begin
      bus_ack_i = 1'b0;
      bus_err_i = 1'b0;
    end else if (bus_ack_i || bus_err_i) begin
      bus_ack_i = 1'b0;
      bus_err_i = 1'b0;
    end else if (bus_req_o) begin
      exp_t e;
      logic [31:0] got_d;
      got_d = bus_we_o ? bus_wdata_o : rdfn(bus_addr_o);
      txn_cnt++;
      if (inj_en && bus_addr_o == inj_addr && bus_we_o == inj_we) begin
        bus_err_i = 1'b1;
        inj_en = 1'b0;
      end else begin
        bus_ack_i   = 1'b1;
        bus_rdata_i = rdfn(bus_addr_o);
      end
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected bus txn", bus_addr_o, 32'h0);
      end else begin
        e = exp_q.pop_front();
        chk(bus_we_o == e.we, {e.tag, " dir"}, {31'h0, bus_we_o}, {31'h0, e.we});
        chk(bus_addr_o == e.addr, {e.tag, " addr"}, bus_addr_o, e.addr);
        chk(got_d == e.data, {e.tag, " data"}, got_d, e.data);
        chk(bus_size_o == e.size, {e.tag, " size"}, {30'h0, bus_size_o}, {30'h0, e.size});
      end
    end
  end

  task automatic push_run(input logic [31:0] s, input logic [31:0] d, input int nbytes,
                          input int bb, input logic [1:0] sd, input logic [1:0] dd,
                          input logic [1:0] sz, input string tag);
    logic [31:0] sa, da;
    exp_t e;
    sa = s;
    da = d;
    for (int i = 0; i < nbytes / bb; i++) begin
      e.we = 1'b0; e.addr = sa; e.data = rdfn(sa); e.size = sz; e.tag = tag;
      exp_q.push_back(e);
      e.we = 1'b1; e.addr = da;
      exp_q.push_back(e);
      if (sd == 2'b00 || sd == 2'b11) sa = sa + bb;
      if (dd == 2'b00 || dd == 2'b11) da = da + bb;
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] data);
    @(negedge clk);
    reg_we_i = 1'b1; reg_idx_i = idx; reg_wdata_i = data;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] data);
    @(negedge clk);
    reg_we_i = 1'b0; reg_idx_i = idx;
    #1 data = reg_rdata_o;
  endtask

  task automatic rd_chk(input logic [2:0] idx, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(idx, v);
    chk(v == exp, tag, v, exp);
  endtask

  task automatic wait_done(input int target, input string tag);
    int t;
    t = 0;
    while (done_cnt < target && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(done_cnt == target, tag, done_cnt, target);
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
    wr(3'd1, s);
    wr(3'd2, d);
    wr(3'd3, c);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int t0, nd;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(bus_req_o == 1'b0 && done_o == 1'b0 && err_o == 1'b0, "R1 outputs in reset",
        {29'h0, bus_req_o, done_o, err_o}, 32'h0);
    rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) rd_chk(3'(i), 32'h0, "R1 register after reset");
    nd = 0;

    // R2 R4 R5 R6: memory to memory, both incrementing, 3 word beats
    setup(32'h100, 32'h200, 32'd12);
    push_run(32'h100, 32'h200, 12, 4, 2'b00, 2'b00, 2'd2, "R2 m2m beat");
    wr(3'd0, ctl(1, 1, 2'b00, 2'b00, 2'b00, 2'b01));
    nd++;
    wait_done(nd, "R6 done after m2m run");
    rd_chk(3'd4, 32'h10C, "R5 source advanced");
    rd_chk(3'd5, 32'h20C, "R5 dest advanced");
    rd_chk(3'd6, 32'h0, "R4 count reaches zero");
    rd_chk(3'd0, ctl(1, 0, 2'b00, 2'b00, 2'b00, 2'b01), "R6 trigger self clear");

    // R3 R4 R5: peripheral to memory, byte beats, source fixed
    setup(32'h300, 32'h400, 32'd3);
    push_run(32'h300, 32'h400, 3, 1, 2'b10, 2'b00, 2'd0, "R4 byte beat");
    t0 = txn_cnt;
    wr(3'd0, ctl(1, 1, 2'b01, 2'b10, 2'b00, 2'b01));
    rd_chk(3'd0, ctl(1, 1, 2'b01, 2'b10, 2'b00, 2'b01), "R6 trigger reads active");
    repeat (20) @(negedge clk);
    chk(txn_cnt == t0, "R3 no beat without request", txn_cnt, t0);
    periph_req_i = 1'b1;
    nd++;
    wait_done(nd, "R3 done after requests");
    periph_req_i = 1'b0;
    rd_chk(3'd4, 32'h300, "R5 fixed source held");
    rd_chk(3'd5, 32'h403, "R5 dest advanced by bytes");

    // R4 R5: memory to peripheral, half-word beats, dest reserved direction holds
    setup(32'h600, 32'h680, 32'd4);
    push_run(32'h600, 32'h680, 4, 2, 2'b00, 2'b01, 2'd1, "R4 halfword beat");
    periph_req_i = 1'b1;
    wr(3'd0, ctl(1, 1, 2'b10, 2'b00, 2'b01, 2'b10));
    nd++;
    wait_done(nd, "R4 done after halfwords");
    periph_req_i = 1'b0;
    rd_chk(3'd4, 32'h604, "R5 source plus two halfwords");
    rd_chk(3'd5, 32'h680, "R5 reserved direction holds");

    // R8: trigger pending while disabled, peripheral requests ignored
    setup(32'hA00, 32'hB00, 32'd4);
    push_run(32'hA00, 32'hB00, 4, 4, 2'b00, 2'b00, 2'd2, "R8 resumed beat");
    t0 = txn_cnt;
    wr(3'd0, ctl(0, 1, 2'b01, 2'b00, 2'b00, 2'b00));
    periph_req_i = 1'b1;
    repeat (20) @(negedge clk);
    chk(txn_cnt == t0, "R8 disabled ignores request", txn_cnt, t0);
    rd_chk(3'd0, ctl(0, 1, 2'b01, 2'b00, 2'b00, 2'b00), "R8 trigger stays pending");
    wr(3'd0, ctl(1, 0, 2'b01, 2'b00, 2'b00, 2'b00));
    nd++;
    wait_done(nd, "R8 resumes on enable");
    periph_req_i = 1'b0;

    // R7 wrap: source wraps, 2 beats per loop, restarts without trigger
    setup(32'h500, 32'h900, 32'd8);
    for (int k = 0; k < 5; k++)
      push_run(32'h500, 32'h900, 8, 4, 2'b11, 2'b00, 2'd2, "R7 wrap loop");
    t0 = txn_cnt;
    wr(3'd0, ctl(1, 1, 2'b00, 2'b11, 2'b00, 2'b00));
    begin
      int t;
      t = 0;
      while (txn_cnt < t0 + 12 && t < 3000) begin
        @(negedge clk);
        t++;
      end
    end
    chk(txn_cnt >= t0 + 12, "R7 three loops ran", txn_cnt, t0 + 12);
    wr(3'd0, ctl(0, 0, 2'b00, 2'b11, 2'b00, 2'b00));
    chk(done_cnt == nd, "R7 no done in wrap", done_cnt, nd);
    repeat (10) @(negedge clk);
    exp_q.delete();
    t0 = txn_cnt;
    repeat (30) @(negedge clk);
    chk(txn_cnt == t0 && !bus_req_o, "R8 disable stops wrap", txn_cnt, t0);
    rd_chk(3'd0, ctl(0, 1, 2'b00, 2'b11, 2'b00, 2'b00), "R7 trigger kept in wrap");

    // R10 soft reset keeps configuration
    wr(3'd0, 32'h2);
    rd_chk(3'd0, ctl(0, 0, 2'b00, 2'b11, 2'b00, 2'b00), "R10 config kept, trigger cleared");
    rd_chk(3'd6, 32'h0, "R10 count cleared");
    rd_chk(3'd4, 32'h0, "R10 source pointer cleared");
    rd_chk(3'd1, 32'h500, "R10 base kept");

    // R9 bus error on first write
    setup(32'h700, 32'h800, 32'd8);
    push_run(32'h700, 32'h800, 4, 4, 2'b00, 2'b00, 2'd2, "R9 beat before error");
    inj_addr = 32'h800; inj_we = 1'b1; inj_en = 1'b1;
    wr(3'd0, ctl(1, 1, 2'b00, 2'b00, 2'b00, 2'b00));
    repeat (10) @(negedge clk);
    chk(err_o == 1'b1, "R9 error latched", {31'h0, err_o}, 32'h1);
    rd_chk(3'd0, ctl(1, 0, 2'b00, 2'b00, 2'b00, 2'b00), "R9 trigger cleared");
    rd_chk(3'd4, 32'h700, "R9 pointer not advanced");
    rd_chk(3'd7, 32'h1, "R9 status bit");
    t0 = txn_cnt;
    wr(3'd0, ctl(1, 1, 2'b00, 2'b00, 2'b00, 2'b00));
    repeat (20) @(negedge clk);
    chk(txn_cnt == t0 && err_o, "R9 retrigger ignored", txn_cnt, t0);
    chk(done_cnt == nd, "R9 no done on error", done_cnt, nd);
    wr(3'd0, 32'h2);
    chk(err_o == 1'b0, "R10 error cleared", {31'h0, err_o}, 32'h0);
    push_run(32'h700, 32'h800, 8, 4, 2'b00, 2'b00, 2'd2, "R9 rerun after reset");
    wr(3'd0, ctl(1, 1, 2'b00, 2'b00, 2'b00, 2'b00));
    nd++;
    wait_done(nd, "R9 rerun completes");
    rd_chk(3'd5, 32'h808, "R9 rerun dest");

    // R11 reserved mode
    setup(32'hC00, 32'hD00, 32'd8);
    t0 = txn_cnt;
    wr(3'd0, ctl(1, 1, 2'b11, 2'b00, 2'b00, 2'b00));
    repeat (20) @(negedge clk);
    chk(txn_cnt == t0, "R11 reserved mode no bus", txn_cnt, t0);
    rd_chk(3'd0, ctl(1, 0, 2'b11, 2'b00, 2'b00, 2'b00), "R11 trigger not set");

    // R12 zero count
    setup(32'hC00, 32'hD00, 32'd0);
    t0 = txn_cnt;
    wr(3'd0, ctl(1, 1, 2'b00, 2'b00, 2'b00, 2'b00));
    nd++;
    wait_done(nd, "R12 zero count done");
    repeat (5) @(negedge clk);
    chk(txn_cnt == t0 && done_cnt == nd, "R12 no bus, single done", txn_cnt, t0);
    chk(exp_q.size() == 0, "R2 all expected beats seen", exp_q.size(), 0);

    summary();
    $finish;
  end

endmodule